// File: doc/BRIEF.md
# Write-Completion Status Reporter

This block sits between a nonvolatile memory's read path and its host bus. While an internal program or erase cycle runs, it replaces the array data on the read bus with status bits. A host can then poll for completion in two ways. The first watches the top data bit, which reads inverted with respect to the last byte the host loaded. The second watches the bit below it, which changes value on each finished read access.

The page-load logic supplies three inputs: a busy flag, a flag that marks the busy cycle as a chip erase, and the last loaded byte. The bus supplies the active-low chip-enable and output-enable. When the busy flag drops, a settling window follows. During that window only the top bit carries true array data. After the window, the full array byte is passed through. The output-enable pin is meant to steer an external tri-state driver.

Top module: `wrs_top`

## Requirements
- R1: While busy with a write (erase flag low), a read returns on bit 7 the inverse of bit 7 of `last_byte_i`.
- R2: While busy, bit 6 of the first read in a busy cycle is 1. Each completed access then inverts it, so successive reads give 1, 0, 1, ...
- R3: When not busy and past the settling window, repeated reads return `array_i` unchanged, with no toggling.
- R4: For SETTLE_CYC clock edges after busy falls (counting the edge that sees the fall), a read returns bit 7 of `array_i` on bit 7 and zero on bits 6..0.
- R5: From the next edge onward, a read returns the whole of `array_i`.
- R6: When `ce_n` or `oe_n` is high, `dq_oe` is 0 and `dq_o` is all zero.
- R7: The toggle bit returns to 1 at the start of every busy cycle, whatever value it held before.
- R8: While busy with an erase (erase flag high), bit 7 reads 0 and bit 6 toggles as in R2.
- R9: While busy, bits 5..0 read as zero.
- R10: One access flips the toggle bit once, however many cycles it lasts. The flip takes effect on the edge after the access ends.
- R11: If busy rises again inside the settling window, status format resumes at once. When that cycle ends, a full-length settling window follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal write or erase cycle in progress |
| erase_i | input | 1 | Current busy cycle is a chip erase |
| last_byte_i | input | 8 | Last byte loaded by the host |
| array_i | input | 8 | Array read data at the current address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_o | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Drive enable for the external tri-state buffer |

## Verification
The hardest case to reach from the ports is a busy cycle that starts inside the settling window of the previous one. In that case the timer must be dropped and the toggle must be reloaded in the same cycle. The bench drops busy, waits a few edges, and raises busy again well before SETTLE_CYC has elapsed. It then polls and checks that the first read shows bit 6 as 1. Finally it ends the new cycle and checks that the settling window lasts its full length, sampling exactly at the last settled edge and at the edge after it.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  parameter int DATA_W = 8;
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  typedef logic [DATA_W-1:0] data_t;

  // Status byte during a busy cycle: inverted top bit of the last load
  // (forced low during erase), toggle bit below it, the rest zero.
  function automatic data_t busy_byte(data_t last, logic tog, logic erase);
    data_t r;
    r = '0;
    r[POLL_BIT] = erase ? 1'b0 : ~last[POLL_BIT];
    r[TOG_BIT]  = tog;
    return r;
  endfunction

  // Byte during the settling window: only the top bit is trustworthy.
  function automatic data_t settle_byte(data_t arr);
    data_t r;
    r = '0;
    r[POLL_BIT] = arr[POLL_BIT];
    return r;
  endfunction
endpackage

// File: rtl/wrs_edge.sv
module wrs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic q,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= lvl;
  end
  assign rise = lvl & ~q;
  assign fall = ~lvl & q;
endmodule

// File: rtl/wrs_toggle.sv
module wrs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_rise,
  input  logic rd_end,
  output logic tog
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tog <= 1'b1;
    else if (busy_rise)       tog <= 1'b1;
    else if (busy && rd_end)  tog <= ~tog;
  end
endmodule

// File: rtl/wrs_settle.sv
module wrs_settle #(
  parameter int SETTLE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_fall,
  output logic settling
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (busy)           cnt <= '0;
    else if (busy_fall)      cnt <= CW'(SETTLE_CYC);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign settling = ~busy & ((cnt != '0) | busy_fall);
endmodule

// File: rtl/wrs_top.sv
module wrs_top
  import wrs_pkg::*;
#(
  parameter int SETTLE_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_i,
  input  logic       erase_i,
  input  logic [7:0] last_byte_i,
  input  logic [7:0] array_i,
  input  logic       ce_n,
  input  logic       oe_n,
  output logic [7:0] dq_o,
  output logic       dq_oe
);
  logic rd_act, rd_q, rd_start, rd_end;
  logic busy_q, busy_rise, busy_fall;
  logic tog_q, settling;
  data_t sel;

  assign rd_act = ~ce_n & ~oe_n;

  wrs_edge u_rd_edge (
    .clk(clk), .rst_n(rst_n), .lvl(rd_act),
    .q(rd_q), .rise(rd_start), .fall(rd_end)
  );

  wrs_edge u_busy_edge (
    .clk(clk), .rst_n(rst_n), .lvl(busy_i),
    .q(busy_q), .rise(busy_rise), .fall(busy_fall)
  );

  wrs_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .busy(busy_i),
    .busy_rise(busy_rise), .rd_end(rd_end), .tog(tog_q)
  );

  wrs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .busy(busy_i),
    .busy_fall(busy_fall), .settling(settling)
  );

  always_comb begin
    if (busy_i)        sel = busy_byte(last_byte_i, tog_q, erase_i);
    else if (settling) sel = settle_byte(array_i);
    else               sel = array_i;
  end

  assign dq_o  = rd_act ? sel : '0;
  assign dq_oe = rd_act;

  logic unused_ok;
  assign unused_ok = rd_q ^ rd_start ^ busy_q;
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       erase_i,
  input logic [7:0] last_byte_i,
  input logic       ce_n,
  input logic       oe_n,
  input logic [7:0] dq_o,
  input logic       dq_oe,
  input logic       tog_q,
  input logic       rd_end,
  input logic       busy_rise,
  input logic       settling
);
  // R1
  a_r1_poll_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !erase_i && dq_oe) |-> dq_o[7] == ~last_byte_i[7]);
  // R2 / R10
  a_r2_flip_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_end && !busy_rise) |=> tog_q != $past(tog_q));
  // R3
  a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i) |=> $stable(tog_q));
  // R4
  a_r4_settle_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && dq_oe) |-> dq_o[6:0] == 7'd0);
  // R6
  a_r6_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!dq_oe && dq_o == 8'd0));
  // R7
  a_r7_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rise |=> tog_q);
  // R8
  a_r8_erase_top_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && erase_i) |-> dq_o[7] == 1'b0);
  // R9
  a_r9_busy_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> dq_o[5:0] == 6'd0);
endmodule

bind wrs_top wrs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .erase_i(erase_i),
  .last_byte_i(last_byte_i), .ce_n(ce_n), .oe_n(oe_n),
  .dq_o(dq_o), .dq_oe(dq_oe), .tog_q(tog_q), .rd_end(rd_end),
  .busy_rise(busy_rise), .settling(settling)
);

// File: tb/wrs_top_test.sv
module wrs_top_test;
  localparam time CLK_PERIOD = 10;
  localparam int  SETTLE = 50;
  localparam int  WDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busy_i = 1'b0, erase_i = 1'b0;
  logic [7:0] last_byte_i = 8'h00, array_i = 8'hA5;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [7:0] dq_o;
  logic dq_oe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrs_top #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .erase_i(erase_i),
    .last_byte_i(last_byte_i), .array_i(array_i), .ce_n(ce_n), .oe_n(oe_n),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one complete access; returns the byte seen during it
  task automatic rd(output logic [7:0] v);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #1 v = dq_o;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic set_busy(logic b, logic e);
    @(negedge clk); busy_i = b; erase_i = e;
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] st(logic [7:0] last, logic t, logic e);
    return {(e ? 1'b0 : !last[7]), t, 6'b0};
  endfunction

  // busy is low; access held; verifies window length then release
  task automatic settle_window(string tag);
    @(negedge clk); busy_i = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #1 chk({tag, " R4 first edge"}, dq_o, {array_i[7], 7'b0});
    repeat (SETTLE - 1) @(posedge clk);
    #1 chk({tag, " R4 last edge"}, dq_o, {array_i[7], 7'b0});
    @(posedge clk); #1 chk({tag, " R5 full data"}, dq_o, array_i);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R6 reset oe", {7'b0, dq_oe}, 8'h00);
    rd(v); chk("R5 idle read", v, 8'hA5);
  endtask

  task automatic t_hiz();
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1 chk("R6 ce high oe", {7'b0, dq_oe}, 8'h00);
    chk("R6 ce high dq", dq_o, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(posedge clk); #1 chk("R6 oe high oe", {7'b0, dq_oe}, 8'h00);
    chk("R6 oe high dq", dq_o, 8'h00);
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic t_write_poll(logic [7:0] last);
    logic [7:0] v;
    last_byte_i = last;
    set_busy(1'b1, 1'b0);
    rd(v); chk("R1 R2 R9 read1", v, st(last, 1'b1, 1'b0));
    rd(v); chk("R2 read2", v, st(last, 1'b0, 1'b0));
    rd(v); chk("R2 read3", v, st(last, 1'b1, 1'b0));
    rd(v); chk("R2 read4", v, st(last, 1'b0, 1'b0));
    settle_window("write");
  endtask

  task automatic t_idle_frozen();
    logic [7:0] v;
    array_i = 8'h5A;
    rd(v); chk("R3 idle1", v, 8'h5A);
    rd(v); chk("R3 idle2", v, 8'h5A);
    rd(v); chk("R3 idle3", v, 8'h5A);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    last_byte_i = 8'h80;
    set_busy(1'b1, 1'b0);
    rd(v); chk("R7 pre read", v, st(8'h80, 1'b1, 1'b0));
    settle_window("pre");
    set_busy(1'b1, 1'b0);
    rd(v); chk("R7 fresh cycle", v, st(8'h80, 1'b1, 1'b0));
    settle_window("restart");
  endtask

  task automatic t_long_access();
    logic [7:0] v;
    last_byte_i = 8'h3C;
    set_busy(1'b1, 1'b0);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #1 chk("R10 long start", dq_o, st(8'h3C, 1'b1, 1'b0));
    repeat (8) @(posedge clk);
    #1 chk("R10 long held", dq_o, st(8'h3C, 1'b1, 1'b0));
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1;
    rd(v); chk("R10 single flip", v, st(8'h3C, 1'b0, 1'b0));
    settle_window("long");
  endtask

  task automatic t_erase();
    logic [7:0] v;
    last_byte_i = 8'h00;
    set_busy(1'b1, 1'b1);
    rd(v); chk("R8 erase1", v, 8'h40);
    rd(v); chk("R8 erase2", v, 8'h00);
    rd(v); chk("R8 erase3", v, 8'h40);
    settle_window("erase");
  endtask

  task automatic t_reenter();
    logic [7:0] v;
    last_byte_i = 8'h11;
    array_i = 8'hC3;
    set_busy(1'b1, 1'b0);
    rd(v); rd(v); chk("R2 before reenter", v, st(8'h11, 1'b0, 1'b0));
    set_busy(1'b0, 1'b0);
    repeat (3) @(posedge clk);
    set_busy(1'b1, 1'b0);
    rd(v); chk("R11 status resumes", v, st(8'h11, 1'b1, 1'b0));
    settle_window("reenter R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_hiz();
    t_write_poll(8'h3C);
    t_write_poll(8'h80);
    t_idle_frozen();
    t_restart();
    t_long_access();
    t_erase();
    t_reenter();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule